// File: doc/BRIEF.md
# Pipelined Fixed-Point Divide / Square-Root / Inverse-Root Core

This block is a fully pipelined unsigned fixed-point arithmetic unit. It can start a new operation on every clock. The operation code picks one of three functions: divide with remainder, square root with remainder, or reciprocal square root with remainder. The code may change from one cycle to the next. A second operand port carries either the divisor or the radicand. A wider dividend port is read only by division.

Inside, a setup stage turns each request into a target value and a cost function. A chain of restoring digit-recurrence stages then finds the largest result whose cost does not exceed the target, working from the most significant digit down. Each stage resolves `L` result bits, one radix-2^L digit. A final stage subtracts the cost of the chosen result from the target and scales that difference into the wide remainder. The operation code moves down a separate control pipe next to the data. Every stage ends in a register, so the latency is ceil(W/L)+2 clocks.

Top module: `divsq_core`

## Requirements
- R1: While `rstN` is low, `quotRoot` and `remainder` both read zero.
- R2: A request sampled at one rising edge gives its result on the outputs right after the ceil(W/L)+2-th rising edge from that one. This is 10 edges with the defaults. A different request may be issued on every cycle.
- R3: Division (opCode 0). `quotRoot` is floor(dividend / divRad), with both taken as raw bit patterns. The dividend has W+F bits, 2F of them fractional. This holds whenever that quotient fits in W bits.
- R4: Division remainder. `remainder` equals (dividend mod divRad) shifted left by F bits.
- R5: Square root (opCode 1). `quotRoot` is the largest R with R² ≤ divRad·2^F. `remainder` is (divRad·2^F − R²) shifted left by F bits.
- R6: Reciprocal square root (opCode 2) of a nonzero operand. `quotRoot` is the largest R with R²·divRad ≤ 2^(3F). `remainder` is 2^(3F) − R²·divRad, with no shift.
- R7: Division by zero. `quotRoot` is all ones and `remainder` is the dividend shifted left by F bits. No flag is raised.
- R8: Reciprocal square root of zero. `quotRoot` is all ones and `remainder` is 2^(3F).
- R9: opCode 3 gives the same results as division.
- R10: For opCodes 1 and 2, the value on `dividend` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 2 | 0 divide, 1 square root, 2 reciprocal square root, 3 divide |
| dividend | input | W+F | Dividend, 2F fractional bits |
| divRad | input | W | Divisor or radicand, F fractional bits |
| quotRoot | output | W | Quotient or root, F fractional bits |
| remainder | output | 3W | Remainder, 3F fractional bits |

## Verification
The assertions keep their own delayed copy of each request. They check the divide identity only when the divisor is nonzero and the dividend is below divisor·2^W, which is the condition for the true quotient to fit in W bits. They check the root identities for every radicand, and the reciprocal identity for every nonzero operand. The bench keeps every division inside the same domain by drawing the dividend below that bound. It covers zero divisors, zero radicands and the spare opCode with directed cases. It sweeps both root operations over every radicand while putting random values on the unused dividend port.

// File: rtl/divsq_pkg.sv
package divsq_pkg;

  typedef enum logic [1:0] {
    OP_DIV   = 2'd0,
    OP_SQRT  = 2'd1,
    OP_RSQRT = 2'd2,
    OP_DIVX  = 2'd3
  } opCode_e;

  // one-hot strobes that steer a datapath stage
  typedef struct packed {
    logic selDiv;
    logic selSqrt;
    logic selRsqrt;
  } opStrobe_t;

  function automatic opStrobe_t decodeOp(logic [1:0] code);
    opStrobe_t s;
    s = '0;
    case (code)
      OP_SQRT:  s.selSqrt  = 1'b1;
      OP_RSQRT: s.selRsqrt = 1'b1;
      default:  s.selDiv   = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/divsq_ctrl.sv
module divsq_ctrl
  import divsq_pkg::*;
#(
  parameter int NS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          opCode,
  output opStrobe_t           setupSel,
  output opStrobe_t [NS-1:0]  stageSel,
  output opStrobe_t           finalSel
);

  // selPipe[k] sits beside the data register feeding stage k (k = NS feeds final)
  opStrobe_t [NS:0] selPipe;

  assign setupSel = decodeOp(opCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selPipe <= '0;
    else       selPipe <= {selPipe[NS-1:0], setupSel};
  end

  assign stageSel = selPipe[NS-1:0];
  assign finalSel = selPipe[NS];

endmodule

// File: rtl/divsq_cost.sv
module divsq_cost
  import divsq_pkg::*;
#(
  parameter int QP = 8,
  parameter int PW = 24
) (
  input  opStrobe_t         sel,
  input  logic [QP-1:0]     cand,
  input  logic [QP-1:0]     opnd,
  output logic [PW-1:0]     cost
);

  logic [PW-1:0] candW;
  logic [PW-1:0] opndW;

  assign candW = PW'(cand);
  assign opndW = PW'(opnd);

  always_comb begin
    if (sel.selDiv)       cost = candW * opndW;
    else if (sel.selSqrt) cost = candW * candW;
    else                  cost = candW * candW * opndW;
  end

endmodule

// File: rtl/divsq_stage.sv
module divsq_stage
  import divsq_pkg::*;
#(
  parameter int QP    = 8,
  parameter int PW    = 24,
  parameter int L     = 1,
  parameter int SHIFT = 7
) (
  input  opStrobe_t      sel,
  input  logic [QP-1:0]  partialIn,
  input  logic [QP-1:0]  opnd,
  input  logic [PW-1:0]  target,
  output logic [QP-1:0]  partialOut
);

  localparam int RADIX = 1 << L;
  localparam int NCAND = RADIX - 1;

  logic [QP-1:0] candV [NCAND];
  logic [PW-1:0] costV [NCAND];
  logic          fitV  [NCAND];

  for (genvar j = 0; j < NCAND; j++) begin : g_digit
    assign candV[j] = partialIn | (QP'(j + 1) << SHIFT);
    divsq_cost #(.QP(QP), .PW(PW)) cost_i (
      .sel  (sel),
      .cand (candV[j]),
      .opnd (opnd),
      .cost (costV[j])
    );
    assign fitV[j] = (costV[j] <= target);
  end

  // cost grows with the digit, so the highest fitting digit is kept
  always_comb begin
    partialOut = partialIn;
    for (int j = 0; j < NCAND; j++) begin
      if (fitV[j]) partialOut = candV[j];
    end
  end

endmodule

// File: rtl/divsq_datapath.sv
module divsq_datapath
  import divsq_pkg::*;
#(
  parameter int W = 8,
  parameter int F = 4,
  parameter int L = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  opStrobe_t                     setupSel,
  input  opStrobe_t [(W+L-1)/L-1:0]     stageSel,
  input  opStrobe_t                     finalSel,
  input  logic [W+F-1:0]                dividend,
  input  logic [W-1:0]                  divRad,
  output logic [W-1:0]                  quotRoot,
  output logic [3*W-1:0]                remainder
);

  localparam int NS = (W + L - 1) / L;
  localparam int QP = NS * L;
  localparam int PW = 3 * QP;

  logic [PW-1:0] tgtR  [NS+1];
  logic [QP-1:0] oprR  [NS+1];
  logic [QP-1:0] rootR [NS+1];
  logic [QP-1:0] nextRoot [NS];

  // setup: choose the bound that the result's cost must not exceed
  logic [PW-1:0] setupTgt;
  always_comb begin
    if (setupSel.selDiv)       setupTgt = PW'(dividend);
    else if (setupSel.selSqrt) setupTgt = PW'(divRad) << F;
    else                       setupTgt = PW'(1) << (3 * F);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtR[0]  <= '0;
      oprR[0]  <= '0;
      rootR[0] <= '0;
    end else begin
      tgtR[0]  <= setupTgt;
      oprR[0]  <= QP'(divRad);
      rootR[0] <= '0;
    end
  end

  for (genvar k = 0; k < NS; k++) begin : g_calc
    divsq_stage #(.QP(QP), .PW(PW), .L(L), .SHIFT(QP - L * (k + 1))) stage_i (
      .sel        (stageSel[k]),
      .partialIn  (rootR[k]),
      .opnd       (oprR[k]),
      .target     (tgtR[k]),
      .partialOut (nextRoot[k])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tgtR[k+1]  <= '0;
        oprR[k+1]  <= '0;
        rootR[k+1] <= '0;
      end else begin
        tgtR[k+1]  <= tgtR[k];
        oprR[k+1]  <= oprR[k];
        rootR[k+1] <= nextRoot[k];
      end
    end
  end

  // final: leftover = target - cost(result), then per-operation scaling
  logic [PW-1:0] finalCost;
  logic [PW-1:0] leftOver;
  logic [PW-1:0] scaledRem;

  divsq_cost #(.QP(QP), .PW(PW)) finalCost_i (
    .sel  (finalSel),
    .cand (rootR[NS]),
    .opnd (oprR[NS]),
    .cost (finalCost)
  );

  assign leftOver  = tgtR[NS] - finalCost;
  assign scaledRem = finalSel.selRsqrt ? leftOver : (leftOver << F);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotRoot  <= '0;
      remainder <= '0;
    end else begin
      quotRoot  <= rootR[NS][W-1:0];
      remainder <= scaledRem[3*W-1:0];
    end
  end

endmodule

// File: rtl/divsq_core.sv
module divsq_core
  import divsq_pkg::*;
#(
  parameter int W = 8,
  parameter int F = 4,
  parameter int L = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opCode,
  input  logic [W+F-1:0]   dividend,
  input  logic [W-1:0]     divRad,
  output logic [W-1:0]     quotRoot,
  output logic [3*W-1:0]   remainder
);

  localparam int NS = (W + L - 1) / L;

  opStrobe_t           setupSel;
  opStrobe_t [NS-1:0]  stageSel;
  opStrobe_t           finalSel;

  divsq_ctrl #(.NS(NS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .opCode   (opCode),
    .setupSel (setupSel),
    .stageSel (stageSel),
    .finalSel (finalSel)
  );

  divsq_datapath #(.W(W), .F(F), .L(L)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .setupSel  (setupSel),
    .stageSel  (stageSel),
    .finalSel  (finalSel),
    .dividend  (dividend),
    .divRad    (divRad),
    .quotRoot  (quotRoot),
    .remainder (remainder)
  );

endmodule

// File: rtl/divsq_checker.sv
module divsq_checker #(
  parameter int W = 8,
  parameter int F = 4,
  parameter int L = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       opCode,
  input logic [W+F-1:0]   dividend,
  input logic [W-1:0]     divRad,
  input logic [W-1:0]     quotRoot,
  input logic [3*W-1:0]   remainder
);

  localparam int NS  = (W + L - 1) / L;
  localparam int LAT = NS + 2;
  localparam int QP  = NS * L;
  localparam int EW  = 3 * QP + W + 2;
  localparam int CW  = $clog2(LAT + 1);

  logic [1:0]     hOp  [LAT];
  logic [W+F-1:0] hDvd [LAT];
  logic [W-1:0]   hOpr [LAT];
  logic [CW-1:0]  warmCnt;
  logic           warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
      for (int k = 0; k < LAT; k++) begin
        hOp[k]  <= '0;
        hDvd[k] <= '0;
        hOpr[k] <= '0;
      end
    end else begin
      if (warmCnt != CW'(LAT)) warmCnt <= warmCnt + 1'b1;
      hOp[0]  <= opCode;
      hDvd[0] <= dividend;
      hOpr[0] <= divRad;
      for (int k = 1; k < LAT; k++) begin
        hOp[k]  <= hOp[k-1];
        hDvd[k] <= hDvd[k-1];
        hOpr[k] <= hOpr[k-1];
      end
    end
  end

  assign warm = (warmCnt == CW'(LAT));

  logic [EW-1:0] qE, rE, dE, nE;
  logic isDiv, isSqrt, isRsqrt, divFits;

  always_comb begin
    qE      = EW'(quotRoot);
    rE      = EW'(remainder);
    dE      = EW'(hOpr[LAT-1]);
    nE      = EW'(hDvd[LAT-1]);
    isDiv   = (hOp[LAT-1] == 2'd0) || (hOp[LAT-1] == 2'd3);
    isSqrt  = (hOp[LAT-1] == 2'd1);
    isRsqrt = (hOp[LAT-1] == 2'd2);
    divFits = (dE != '0) && (nE < (dE << W));
  end

  // R3 R9: quotient times divisor plus unscaled remainder rebuilds the dividend
  a_r3_div_identity: assert property (@(posedge clk) disable iff (!rstN)
    warm && isDiv && divFits |-> (qE * dE + (rE >> F)) == nE);

  // R4: remainder is scaled by F and smaller than the divisor
  a_r4_div_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    warm && isDiv && divFits |-> ((rE >> F) < dE) && (remainder[F-1:0] == '0));

  // R5: root identity and maximality of the root
  a_r5_sqrt_identity: assert property (@(posedge clk) disable iff (!rstN)
    warm && isSqrt |-> ((qE * qE + (rE >> F)) == (dE << F)) && ((rE >> F) <= (qE << 1)));

  // R6: reciprocal root identity, remainder unshifted
  a_r6_rsqrt_identity: assert property (@(posedge clk) disable iff (!rstN)
    warm && isRsqrt && (dE != '0) |-> (qE * qE * dE + rE) == (EW'(1) << (3 * F)));

  // R7: zero divisor saturates the quotient
  a_r7_div_zero: assert property (@(posedge clk) disable iff (!rstN)
    warm && isDiv && (dE == '0) |-> (quotRoot == '1) && (rE == (nE << F)));

  // R8: reciprocal root of zero saturates the root
  a_r8_rsqrt_zero: assert property (@(posedge clk) disable iff (!rstN)
    warm && isRsqrt && (dE == '0) |-> (quotRoot == '1) && (rE == (EW'(1) << (3 * F))));

endmodule

bind divsq_core divsq_checker #(.W(W), .F(F), .L(L)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opCode    (opCode),
  .dividend  (dividend),
  .divRad    (divRad),
  .quotRoot  (quotRoot),
  .remainder (remainder)
);

// File: tb/divsq_core_tb_top.sv
`timescale 1ns/1ps
module divsq_core_tb_top;

  localparam int W   = 8;
  localparam int F   = 4;
  localparam int L   = 1;
  localparam int LAT = (W + L - 1) / L + 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       opCode = '0;
  logic [W+F-1:0]   dividend = '0;
  logic [W-1:0]     divRad = '0;
  logic [W-1:0]     quotRoot;
  logic [3*W-1:0]   remainder;

  always #2 clk = ~clk;

  divsq_core #(.W(W), .F(F), .L(L)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .opCode    (opCode),
    .dividend  (dividend),
    .divRad    (divRad),
    .quotRoot  (quotRoot),
    .remainder (remainder)
  );

  typedef struct {
    int              due;
    logic [W-1:0]    q;
    logic [3*W-1:0]  r;
    string           tag;
  } expItem_t;

  expItem_t sb[$];
  int compared = 0;
  int mismatched = 0;
  int edgeCount = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rstN) edgeCount <= edgeCount + 1;

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // reference model written from the requirements
  task automatic model(input logic [1:0] op, input longint n, input longint d,
                       output logic [W-1:0] q, output logic [3*W-1:0] r,
                       output string tag);
    longint best;
    if (op == 2'd0 || op == 2'd3) begin
      if (d == 0) begin
        q = '1; r = (3*W)'(n << F); tag = "R7";
      end else begin
        q = W'(n / d); r = (3*W)'((n % d) << F);
        tag = (op == 2'd3) ? "R9" : "R3 R4";
      end
    end else if (op == 2'd1) begin
      best = 0;
      for (longint c = 0; c < (1 << W); c++) if (c * c <= (d << F)) best = c;
      q = W'(best); r = (3*W)'(((d << F) - best * best) << F); tag = "R5 R10";
    end else begin
      if (d == 0) begin
        q = '1; r = (3*W)'(longint'(1) << (3*F)); tag = "R8 R10";
      end else begin
        best = 0;
        for (longint c = 0; c < (1 << W); c++) if (c * c * d <= (longint'(1) << (3*F))) best = c;
        q = W'(best); r = (3*W)'((longint'(1) << (3*F)) - best * best * d); tag = "R6 R10";
      end
    end
  endtask

  // driver: called at a falling edge, presents one request, queues its result
  task automatic issue(input logic [1:0] op, input int n, input int d, input string extra);
    expItem_t it;
    opCode   = op;
    dividend = (W+F)'(n);
    divRad   = W'(d);
    model(op, longint'(n), longint'(d), it.q, it.r, it.tag);
    it.tag = {it.tag, extra};
    it.due = edgeCount + LAT;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compares each queued item on the cycle it falls due (R2)
  always @(negedge clk) begin
    if (rstN && !done) begin
      while (sb.size() > 0 && sb[0].due == edgeCount) begin
        compared++;
        if (quotRoot !== sb[0].q || remainder !== sb[0].r) begin
          mismatched++;
          $display("FAIL %s R2: q=%0d exp %0d rem=%0d exp %0d",
                   sb[0].tag, quotRoot, sb[0].q, remainder, sb[0].r);
        end
        void'(sb.pop_front());
      end
    end
  end

  function automatic int randDiv(input int d);
    int lim;
    lim = d * (1 << W);
    if (lim > (1 << (W+F))) lim = 1 << (W+F);
    return int'($urandom % lim);
  endfunction

  initial begin
    // R1: outputs cleared during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      opCode = 2'(i); dividend = 12'hABC; divRad = 8'h5A;
      compared++;
      if (quotRoot !== '0 || remainder !== '0) begin
        mismatched++;
        $display("FAIL R1: q=%0d exp 0 rem=%0d exp 0", quotRoot, remainder);
      end
    end
    rstN = 1'b1;

    // directed division in range, including exact and zero dividend (R3 R4)
    issue(2'd0, 100, 7, "");
    issue(2'd0, 255, 1, "");
    issue(2'd0, 0, 9, "");
    issue(2'd0, 4080, 255, "");
    issue(2'd0, 144, 12, "");
    issue(2'd0, 1000, 5, "");
    issue(2'd0, 4095, 16, "");
    // divide by zero (R7)
    issue(2'd0, 77, 0, "");
    issue(2'd0, 4095, 0, "");
    issue(2'd3, 0, 0, "");
    // spare code behaves as divide (R9)
    issue(2'd3, 500, 3, "");
    issue(2'd3, 4000, 250, "");
    // random division inside the quotient-fits domain
    for (int i = 0; i < 40; i++) begin
      int d;
      d = 1 + int'($urandom % 255);
      issue(2'd0, randDiv(d), d, "");
    end
    // square root over every radicand, junk on the dividend (R5 R10)
    for (int r = 0; r < (1 << W); r++) issue(2'd1, int'($urandom % 4096), r, "");
    // reciprocal square root over every operand (R6 R8 R10)
    for (int r = 0; r < (1 << W); r++) issue(2'd2, int'($urandom % 4096), r, "");
    // back-to-back mixed operations (R2)
    for (int i = 0; i < 120; i++) begin
      logic [1:0] op;
      int d;
      op = 2'($urandom % 4);
      d  = int'($urandom % 256);
      if (op == 2'd1 || op == 2'd2) issue(op, int'($urandom % 4096), d, " mixed");
      else if (d == 0)              issue(op, int'($urandom % 4096), 0, " mixed");
      else                          issue(op, randDiv(d), d, " mixed");
    end

    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not complete, %0d items pending exp 0", sb.size());
      report();
      $finish;
    end
  end

endmodule